// File: doc/BRIEF.md
# 16-bit Auto-Reload Timer/Counter

This block is a 16-bit up-counter with its own reload register pair and a single control byte that holds both the control bits and the overflow flag. It advances either once per machine cycle (one machine cycle is a fixed number of system clocks, 12 by default) or on falling transitions of an external count pin. The count pin is sampled once per machine cycle. Counting needs a run bit. When the gate bit is set, counting also needs an external gate pin to be high.

When the count steps past all-ones, it is loaded from the reload registers. Those registers are never changed by the overflow. An overflow also raises a flag, and that flag is the interrupt request. An interrupt controller clears the flag through a dedicated clear input. Software can also set or clear the flag directly.

Everything runs on the system clock, using enables. Software reaches the control byte, the two counter bytes and the two reload bytes through a simple byte-wide register port.

Top module: `reload_timer16`

## Requirements
- R1: After reset, the control byte, both counter bytes and both reload bytes read zero, and `irqFlag` is low.
- R2: In timer mode (control bit 6 = 0), an enabled counter adds one on every 12th system clock edge. Machine cycles are counted from the release of reset, so the first step falls on the 12th edge after reset.
- R3: In counter mode (control bit 6 = 1), `cntPin` is sampled once per machine cycle. The count adds one in the machine cycle where the sample is 0 and the previous sample was 1. A pulse that starts and ends between two samples is not counted.
- R4: Counting needs run (control bit 4) = 1. When gate (control bit 7) = 1, counting also needs `gatePin` = 1. Otherwise the count holds.
- R5: A step from 0xFFFF loads the counter with the reload value. The reload bytes keep their value.
- R6: An overflow sets the flag (control bit 5), which `irqFlag` mirrors. A pulse on `flagClr` clears the flag.
- R7: A software write to the control byte loads the flag from data bit 5. An overflow in the same cycle as a `flagClr` or a software clear leaves the flag set.
- R8: A write to a counter byte in the cycle of a step loads the written value. No step happens in that cycle.
- R9: The register map is as follows:
  - 0: control byte, with bits 3..0 reading zero.
  - 1: counter low byte.
  - 2: counter high byte.
  - 3: reload low byte.
  - 4: reload high byte.

  Reads are combinational. Addresses 5 to 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr` |
| cntPin | input | 1 | External count input |
| gatePin | input | 1 | External gate input |
| flagClr | input | 1 | Clears the overflow flag (interrupt acknowledge) |
| irqFlag | output | 1 | Overflow flag / interrupt request |

## Verification
The hardest situations to reach are the collisions at a step edge: a software counter write, or a flag clear, landing in the very cycle where the machine-cycle boundary causes a step or an overflow. The bench keeps its own machine-cycle phase count from the release of reset. It drives the colliding write or `flagClr` in the half cycle just before the predicted boundary. The same phase model is used to place short count-pin pulses strictly between two samples, so that R3 can be shown to ignore them.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;

  localparam int BYTE_W   = 8;
  localparam int IDX_W    = 4;

  // control byte bit positions
  localparam int GATE_BIT = 7;
  localparam int SRC_BIT  = 6;
  localparam int FLAG_BIT = 5;
  localparam int RUN_BIT  = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic              step;
    logic              cntWr;
    logic              rldWr;
    logic [IDX_W-1:0]  byteIdx;
    logic [BYTE_W-1:0] data;
  } dpStrobe_t;

endpackage

// File: rtl/rtimer_datapath.sv
module rtimer_datapath
  import rtimer_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int NBYTES = CNT_W / BYTE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             ovf
);

  logic [CNT_W-1:0] countNext;
  logic [CNT_W-1:0] reloadNext;
  logic [CNT_W-1:0] countInc;
  logic             atMax;

  assign atMax    = &count;
  assign countInc = count + CNT_W'(1);
  assign ovf      = strb.step && !strb.cntWr && atMax;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic selCnt;
    logic selRld;
    assign selCnt = strb.cntWr && (strb.byteIdx == IDX_W'(i));
    assign selRld = strb.rldWr && (strb.byteIdx == IDX_W'(i));

    always_comb begin
      if (strb.cntWr)
        countNext[i*BYTE_W +: BYTE_W] = selCnt ? strb.data : count[i*BYTE_W +: BYTE_W];
      else if (strb.step)
        countNext[i*BYTE_W +: BYTE_W] = atMax ? reload[i*BYTE_W +: BYTE_W]
                                              : countInc[i*BYTE_W +: BYTE_W];
      else
        countNext[i*BYTE_W +: BYTE_W] = count[i*BYTE_W +: BYTE_W];
      reloadNext[i*BYTE_W +: BYTE_W] = selRld ? strb.data : reload[i*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      reload <= '0;
    end else begin
      count  <= countNext;
      reload <= reloadNext;
    end
  end

  AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> count == $past(reload)); // R5
  AST_RELOAD_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rldWr |=> $stable(reload)); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntWr && strb.byteIdx == '0) |=> count[BYTE_W-1:0] == $past(strb.data)); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.cntWr && !atMax) |=> count == $past(count) + CNT_W'(1)); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step && !strb.cntWr) |=> $stable(count)); // R4

endmodule

// File: rtl/rtimer_ctrl.sv
module rtimer_ctrl
  import rtimer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 12,
  localparam int NBYTES  = CNT_W / BYTE_W,
  localparam int ADDR_W  = $clog2(2*NBYTES+1),
  localparam int PRE_W   = $clog2(PRESCALE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  input  logic              cntPin,
  input  logic              gatePin,
  input  logic              flagClr,
  input  logic              ovf,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  reload,
  output dpStrobe_t         strb,
  output logic [BYTE_W-1:0] regRdata,
  output logic              irqFlag
);

  logic             gateEn;
  logic             srcExt;
  logic             runEn;
  logic             flag;
  logic [PRE_W-1:0] presc;
  logic             tick;
  logic             lastSample;
  logic             pinFall;
  logic             enable;
  logic             ctrlWr;
  int               addrInt;

  assign addrInt = int'(regAddr);
  assign tick    = (presc == PRE_W'(PRESCALE-1));
  assign pinFall = lastSample && !cntPin;
  assign enable  = runEn && (!gateEn || gatePin);
  assign ctrlWr  = regWr && (addrInt == 0);

  // machine-cycle prescaler and count-pin sampler
  always_ff @(posedge clk) begin
    if (!rstN) begin
      presc      <= '0;
      lastSample <= 1'b0;
    end else begin
      presc <= tick ? '0 : presc + PRE_W'(1);
      if (tick) lastSample <= cntPin;
    end
  end

  // control byte and flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateEn <= 1'b0;
      srcExt <= 1'b0;
      runEn  <= 1'b0;
      flag   <= 1'b0;
    end else begin
      if (ctrlWr) begin
        gateEn <= regWdata[GATE_BIT];
        srcExt <= regWdata[SRC_BIT];
        runEn  <= regWdata[RUN_BIT];
      end
      if (ovf)          flag <= 1'b1;
      else if (flagClr) flag <= 1'b0;
      else if (ctrlWr)  flag <= regWdata[FLAG_BIT];
    end
  end

  // strobes toward the datapath
  always_comb begin
    strb.step    = tick && enable && (srcExt ? pinFall : 1'b1);
    strb.cntWr   = regWr && (addrInt >= 1) && (addrInt <= NBYTES);
    strb.rldWr   = regWr && (addrInt >= NBYTES + 1) && (addrInt <= 2*NBYTES);
    strb.byteIdx = strb.rldWr ? IDX_W'(addrInt - 1 - NBYTES) : IDX_W'(addrInt - 1);
    strb.data    = regWdata;
  end

  // read mux
  always_comb begin
    regRdata = '0;
    if (addrInt == 0) begin
      regRdata[GATE_BIT] = gateEn;
      regRdata[SRC_BIT]  = srcExt;
      regRdata[FLAG_BIT] = flag;
      regRdata[RUN_BIT]  = runEn;
    end
    for (int i = 0; i < NBYTES; i++) begin
      if (addrInt == i + 1)          regRdata = count[i*BYTE_W +: BYTE_W];
      if (addrInt == i + 1 + NBYTES) regRdata = reload[i*BYTE_W +: BYTE_W];
    end
  end

  assign irqFlag = flag;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> irqFlag); // R6
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !ovf) |=> !irqFlag); // R6
  AST_SW_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !ovf && !flagClr) |=> irqFlag == $past(regWdata[FLAG_BIT])); // R7
  AST_STEP_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> !strb.step); // R2
  AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (gateEn && !gatePin) |-> !strb.step); // R4

endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
  import rtimer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 12,
  localparam int NBYTES  = CNT_W / BYTE_W,
  localparam int ADDR_W  = $clog2(2*NBYTES+1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  input  logic              cntPin,
  input  logic              gatePin,
  input  logic              flagClr,
  output logic              irqFlag
);

  dpStrobe_t        strb;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] reload;
  logic             ovf;

  rtimer_ctrl #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .cntPin(cntPin), .gatePin(gatePin),
    .flagClr(flagClr), .ovf(ovf), .count(count), .reload(reload),
    .strb(strb), .regRdata(regRdata), .irqFlag(irqFlag)
  );

  rtimer_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .count(count), .reload(reload), .ovf(ovf)
  );

endmodule

// File: tb/tb_reload_timer16.sv
module tb_reload_timer16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       cntPin = 1'b0;
  logic       gatePin = 1'b0;
  logic       flagClr = 1'b0;
  logic       irqFlag;

  int checks = 0;
  int fails  = 0;
  int phase  = 0;

  always #10 clk = ~clk;

  reload_timer16 dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .cntPin(cntPin),
    .gatePin(gatePin), .flagClr(flagClr), .irqFlag(irqFlag)
  );

  // bench's own machine-cycle model: step edge when phase==11 before the edge
  always @(posedge clk) if (rstN) phase <= (phase == 11) ? 0 : phase + 1;

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  task automatic wrReg(int a, int d);
    @(negedge clk);
    regWr = 1'b1; regAddr = 3'(a); regWdata = 8'(d);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(int a, output int d);
    regAddr = 3'(a);
    #1 d = int'(regRdata);
  endtask

  task automatic rdCount(output int c);
    int lo, hi;
    rdReg(1, lo); rdReg(2, hi);
    c = hi * 256 + lo;
  endtask

  // leave at the negedge just after the n-th following step edge
  task automatic passTicks(int n);
    repeat (n) begin
      @(negedge clk);
      while (phase != 0) @(negedge clk);
    end
  endtask

  task automatic toPreTick();
    @(negedge clk);
    while (phase != 11) @(negedge clk);
  endtask

  task automatic setCount(int v);
    wrReg(0, 0);
    wrReg(1, v & 8'hFF);
    wrReg(2, (v >> 8) & 8'hFF);
  endtask

  task automatic testReset();
    int v;
    for (int a = 0; a < 5; a++) begin
      rdReg(a, v); check("R1 reg after reset", v, 0);
    end
    check("R1 irqFlag after reset", int'(irqFlag), 0);
  endtask

  task automatic testStopped();
    int c;
    setCount(16'h0042);
    repeat (40) @(negedge clk);
    rdCount(c); check("R4 run=0 holds", c, 16'h0042);
  endtask

  task automatic testTimerWrap();
    int c, v;
    setCount(16'hFFFD);
    wrReg(3, 8'h34); wrReg(4, 8'h12);
    wrReg(0, 8'h10);
    passTicks(1); rdCount(c); check("R2 step 1", c, 16'hFFFE);
    repeat (6) @(negedge clk);
    rdCount(c); check("R2 no step mid cycle", c, 16'hFFFE);
    passTicks(1); rdCount(c); check("R2 step 2", c, 16'hFFFF);
    check("R6 flag low before wrap", int'(irqFlag), 0);
    passTicks(1); rdCount(c); check("R5 reload on wrap", c, 16'h1234);
    check("R6 flag on wrap", int'(irqFlag), 1);
    rdReg(0, v); check("R6 flag bit5 in control", v, 8'h30);
    rdReg(3, v); check("R5 reload low kept", v, 8'h34);
    rdReg(4, v); check("R5 reload high kept", v, 8'h12);
    passTicks(1); rdCount(c); check("R5 counts on from reload", c, 16'h1235);
  endtask

  task automatic testFlag();
    @(negedge clk); flagClr = 1'b1; @(negedge clk); flagClr = 1'b0;
    check("R6 flagClr clears", int'(irqFlag), 0);
    wrReg(0, 8'h20); check("R7 sw set", int'(irqFlag), 1);
    wrReg(0, 8'h00); check("R7 sw clear", int'(irqFlag), 0);
  endtask

  task automatic testCollideFlag();
    int c;
    setCount(16'hFFFF);
    wrReg(0, 8'h10);
    toPreTick();
    rdCount(c);
    if (c == 16'hFFFF) begin
      flagClr = 1'b1; @(negedge clk); flagClr = 1'b0;
      check("R7 hw set beats clear", int'(irqFlag), 1);
      rdCount(c); check("R5 wrap during clear", c, 16'h1234);
    end else check("R7 setup reached FFFF", c, 16'hFFFF);
    wrReg(0, 8'h00);
  endtask

  task automatic testWritePriority();
    int c;
    setCount(16'h0010);
    wrReg(0, 8'h10);
    toPreTick();
    regWr = 1'b1; regAddr = 3'd1; regWdata = 8'h80;
    @(negedge clk); regWr = 1'b0;
    rdCount(c); check("R8 write beats step", c, 16'h0080);
    passTicks(1); rdCount(c); check("R8 next step", c, 16'h0081);
  endtask

  task automatic testGate();
    int c;
    setCount(16'h0000);
    gatePin = 1'b0;
    wrReg(0, 8'h90);
    passTicks(3); rdCount(c); check("R4 gate low blocks", c, 0);
    gatePin = 1'b1;
    passTicks(2); rdCount(c); check("R4 gate high counts", c, 2);
    gatePin = 1'b0;
    passTicks(1); rdCount(c); check("R4 gate dropped", c, 2);
  endtask

  task automatic testCounter();
    int c;
    setCount(16'h0000);
    cntPin = 1'b0;
    wrReg(0, 8'h50);
    passTicks(1);
    for (int k = 0; k < 3; k++) begin
      cntPin = 1'b1; passTicks(2);
      cntPin = 1'b0; passTicks(2);
    end
    rdCount(c); check("R3 three falling samples", c, 3);
    // short pulse strictly between two samples
    @(negedge clk); while (phase != 3) @(negedge clk);
    cntPin = 1'b1; @(negedge clk); @(negedge clk); cntPin = 1'b0;
    passTicks(3); rdCount(c); check("R3 short pulse unseen", c, 3);
    cntPin = 1'b1; passTicks(1);
    rdCount(c); check("R3 rising edge no count", c, 3);
    cntPin = 1'b0; passTicks(1);
    rdCount(c); check("R3 falling edge counts", c, 4);
    wrReg(0, 8'h00);
  endtask

  task automatic testMap();
    int v, c;
    wrReg(0, 8'hFF);
    rdReg(0, v); check("R9 control low bits zero", v, 8'hF0);
    wrReg(0, 8'h00);
    setCount(16'hA55A);
    wrReg(5, 8'h77); wrReg(6, 8'h77); wrReg(7, 8'h77);
    for (int a = 5; a < 8; a++) begin
      rdReg(a, v); check("R9 unused reads zero", v, 0);
    end
    rdCount(c); check("R9 unused write no effect count", c, 16'hA55A);
    rdReg(3, v); check("R9 unused write no effect reload", v, 8'h34);
    rdReg(0, v); check("R9 unused write no effect ctrl", v, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testStopped();
    testTimerWrap();
    testFlag();
    testCollideFlag();
    testWritePriority();
    testGate();
    testCounter();
    testMap();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule